// File: doc/BRIEF.md
# Key Matrix Event Encoder

This block scans a switch matrix of up to 8 rows by 12 columns one row at a time and keeps a debounced picture of every key. Only a key whose state has changed produces output. A press yields a make byte and a release yields a break byte. The bytes go into a small queue, and a host drains it through a read strobe. A pending-event output stays high while the queue holds data, and an idle output tells power management that no key is down and nothing is waiting.

Each row line and each column line has its own enable, so unused lines can be left out of the scan. A matrix cannot tell three pressed corners of a rectangle from four. Whenever the scanned picture contains such a rectangle, the block reports nothing for that frame. The pace of the scan comes from a rate value, and a strap input can halve that pace.

Top module: `keymatrix_encoder`

## Requirements
- R1: After reset the queue is empty, the overflow flag is 0, idle is 1 and row 0 is the driven row.
- R2: An event byte holds the column index plus one in bits 3:0 (1 to 12), the row index in bits 6:4, and the direction in bit 7 (0 = press, 1 = release).
- R3: A key that stays unchanged produces no further bytes after its make byte.
- R4: A change is accepted only when two consecutive full scans agree; a change seen in a single scan is dropped.
- R5: While any two scanned rows share two or more pressed columns (a rectangle), no bytes are produced and the stored key state does not change.
- R6: When several keys change in the same scan, their bytes enter the queue in ascending order of row*12+column.
- R7: Any number of keys held at once is tracked and reported, as long as they form no rectangle.
- R8: A row with its enable at 0 is never driven and a column with its enable at 0 is never sensed, so a key on either produces no byte.
- R9: The queue holds 8 bytes, shows the oldest on code_out and removes it on a read strobe.
- R10: A byte pushed into a full queue is dropped and the overflow flag goes to 1 and stays there until reset.
- R11: fifo_nempty and event_req are 1 exactly while the queue holds data; idle is 1 only when no key is held and the queue is empty.
- R12: Each row stays driven for scan_rate+1 clocks, or 2*(scan_rate+1) clocks when half_rate is 1, while no bytes are waiting to be queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_en | input | 8 | Per-row scan enable |
| col_en | input | 12 | Per-column scan enable |
| scan_rate | input | 7 | Row dwell control: each row lasts scan_rate+1 clocks |
| half_rate | input | 1 | Strap that doubles the row dwell |
| sense_col | input | 12 | Column sense lines, 1 = contact closed on the driven row |
| drive_row | output | 8 | One-hot row drive, 1 = row driven |
| rd_strobe | input | 1 | Removes the byte shown on code_out |
| code_out | output | 8 | Oldest queued event byte |
| fifo_nempty | output | 1 | Queue holds at least one byte |
| fifo_ovf | output | 1 | Sticky overflow flag |
| event_req | output | 1 | Request to the host to read events |
| idle | output | 1 | No key held and queue empty |

## Verification
The bench uses the default build: 8 rows, 12 columns, a queue of 8 entries and a 7-bit rate value. With these values, ten keys pressed together on one row overflow the queue, so both the drop rule and the sticky flag can be checked with a single press pattern. A row-dwell rate of 1 keeps each frame at 16 clocks, which puts debounce, ghost frames and ordered emission within a few hundred cycles. The bench's matrix model shorts the fourth corner of a three-key rectangle, so the ghost path sees the same picture a real matrix would give it.

// File: rtl/kme_pkg.sv
package kme_pkg;

  typedef logic [7:0] evcode_t;

  // Event byte: {release, row[2:0], column+1}
  function automatic evcode_t make_code(logic [2:0] row, logic [3:0] col, logic release_ev);
    return {release_ev, row, col + 4'd1};
  endfunction

  // Row dwell limit in clocks minus one
  function automatic logic [7:0] dwell_limit(logic [6:0] rate, logic halve);
    return halve ? {rate, 1'b1} : {1'b0, rate};
  endfunction

endpackage

// File: rtl/kme_scan.sv
module kme_scan #(
  parameter int ROWS   = 8,
  parameter int COLS   = 12,
  parameter int RATE_W = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROWS-1:0]      row_en,
  input  logic [COLS-1:0]      col_en,
  input  logic [RATE_W-1:0]    rate,
  input  logic                 half_rate,
  input  logic                 hold,
  input  logic [COLS-1:0]      sense_col,
  output logic [ROWS-1:0]      drive_row,
  output logic [ROWS*COLS-1:0] frame,
  output logic                 frame_done
);
  localparam int RIW   = $clog2(ROWS);
  localparam int DIV_W = RATE_W + 1;
  localparam int N     = ROWS * COLS;

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_lim;
  logic [RIW-1:0]   row_idx;
  logic [N-1:0]     acc;
  logic             tick;

  always_comb begin
    div_lim = half_rate ? {rate, 1'b1} : {1'b0, rate};
    tick    = !hold && (div_cnt == div_lim);
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_drive
    assign drive_row[g] = (row_idx == RIW'(g)) && row_en[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt    <= '0;
      row_idx    <= '0;
      acc        <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (tick) begin
        div_cnt <= '0;
        acc[row_idx*COLS +: COLS] <= row_en[row_idx] ? (sense_col & col_en) : '0;
        if (row_idx == RIW'(ROWS-1)) begin
          row_idx    <= '0;
          frame_done <= 1'b1;
        end else begin
          row_idx <= row_idx + 1'b1;
        end
      end else if (!hold) begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  assign frame = acc;

endmodule

// File: rtl/kme_detect.sv
module kme_detect
  import kme_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROWS*COLS-1:0] frame,
  input  logic                 frame_done,
  output logic                 push,
  output evcode_t              code,
  output logic                 pending_any,
  output logic                 ghost_hit,
  output logic                 any_held
);
  localparam int N = ROWS * COLS;

  logic [N-1:0] prev_frame;
  logic [N-1:0] key_state;
  logic [N-1:0] pending;
  int unsigned  idx;

  // Two rows sharing two or more closed columns form a rectangle
  function automatic logic has_rect(logic [N-1:0] f);
    logic hit;
    hit = 1'b0;
    for (int r1 = 0; r1 < ROWS; r1++) begin
      for (int r2 = r1 + 1; r2 < ROWS; r2++) begin
        if ($countones(f[r1*COLS +: COLS] & f[r2*COLS +: COLS]) >= 2) hit = 1'b1;
      end
    end
    return hit;
  endfunction

  function automatic int unsigned first_set(logic [N-1:0] v);
    int unsigned pos;
    pos = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) pos = i;
    end
    return pos;
  endfunction

  always_comb begin
    ghost_hit   = frame_done && has_rect(frame);
    pending_any = |pending;
    any_held    = |key_state;
    idx         = first_set(pending);
    push        = pending_any;
    code        = make_code(3'(idx / COLS), 4'(idx % COLS), key_state[idx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_frame <= '0;
      key_state  <= '0;
      pending    <= '0;
    end else if (frame_done) begin
      prev_frame <= frame;
      pending    <= ~(frame ^ prev_frame) & (frame ^ key_state) & {N{~ghost_hit}};
    end else if (pending_any) begin
      pending[idx]   <= 1'b0;
      key_state[idx] <= ~key_state[idx];
    end
  end

endmodule

// File: rtl/kme_fifo.sv
module kme_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         nempty,
  output logic         ovf
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          pop_ok, push_ok;

  always_comb begin
    pop_ok  = pop && (count != '0);
    push_ok = push && ((count != CW'(DEPTH)) || pop_ok);
    nempty  = (count != '0);
    dout    = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
      if (push && !push_ok) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/keymatrix_encoder.sv
module keymatrix_encoder
  import kme_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int COLS   = 12,
  parameter int DEPTH  = 8,
  parameter int RATE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROWS-1:0]   row_en,
  input  logic [COLS-1:0]   col_en,
  input  logic [RATE_W-1:0] scan_rate,
  input  logic              half_rate,
  input  logic [COLS-1:0]   sense_col,
  output logic [ROWS-1:0]   drive_row,
  input  logic              rd_strobe,
  output logic [7:0]        code_out,
  output logic              fifo_nempty,
  output logic              fifo_ovf,
  output logic              event_req,
  output logic              idle
);
  localparam int N = ROWS * COLS;

  logic [N-1:0] frame;
  logic         frame_done;
  logic         push;
  evcode_t      code;
  logic         pending_any;
  logic         ghost_hit;
  logic         any_held;

  kme_scan #(.ROWS(ROWS), .COLS(COLS), .RATE_W(RATE_W)) scan_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_en     (row_en),
    .col_en     (col_en),
    .rate       (scan_rate),
    .half_rate  (half_rate),
    .hold       (pending_any),
    .sense_col  (sense_col),
    .drive_row  (drive_row),
    .frame      (frame),
    .frame_done (frame_done)
  );

  kme_detect #(.ROWS(ROWS), .COLS(COLS)) detect_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame       (frame),
    .frame_done  (frame_done),
    .push        (push),
    .code        (code),
    .pending_any (pending_any),
    .ghost_hit   (ghost_hit),
    .any_held    (any_held)
  );

  kme_fifo #(.DEPTH(DEPTH), .W(8)) fifo_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .din    (code),
    .pop    (rd_strobe),
    .dout   (code_out),
    .nempty (fifo_nempty),
    .ovf    (fifo_ovf)
  );

  assign event_req = fifo_nempty;
  assign idle      = !any_held && !fifo_nempty;

endmodule

// File: rtl/kme_checker.sv
module kme_checker #(
  parameter int ROWS = 8,
  parameter int COLS = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ROWS-1:0] drive_row,
  input logic            rd_strobe,
  input logic            fifo_nempty,
  input logic            fifo_ovf,
  input logic            push,
  input logic [7:0]      code,
  input logic            pending_any,
  input logic            ghost_hit,
  input logic            frame_done
);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf |=> fifo_ovf);

  p_drive_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drive_row));

  p_ghost_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ghost_hit |=> !pending_any);

  p_code_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (code[3:0] >= 4'd1 && code[3:0] <= 4'(COLS)));

  p_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pending_any |=> !frame_done);

  p_keep_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_nempty && !rd_strobe) |=> fifo_nempty);

endmodule

bind keymatrix_encoder kme_checker #(.ROWS(ROWS), .COLS(COLS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .drive_row   (drive_row),
  .rd_strobe   (rd_strobe),
  .fifo_nempty (fifo_nempty),
  .fifo_ovf    (fifo_ovf),
  .push        (push),
  .code        (code),
  .pending_any (pending_any),
  .ghost_hit   (ghost_hit),
  .frame_done  (frame_done)
);

// File: tb/keymatrix_encoder_tb.sv
module keymatrix_encoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 300;
  localparam int WATCHDOG   = 150000;

  // {row[3:0], col[3:0], expected make byte}
  localparam logic [15:0] VEC [6] = '{16'h0001, 16'h5B5C, 16'h2425,
                                      16'h6768, 16'h4A4B, 16'h7071};

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  row_en = 8'hFF;
  logic [11:0] col_en = 12'hFFF;
  logic [6:0]  scan_rate = 7'd1;
  logic        half_rate = 0;
  logic [11:0] sense_col;
  logic [7:0]  drive_row;
  logic        rd_strobe = 0;
  logic [7:0]  code_out;
  logic        fifo_nempty, fifo_ovf, event_req, idle;
  logic [7:0][11:0] keys = '0;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keymatrix_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .row_en(row_en), .col_en(col_en),
    .scan_rate(scan_rate), .half_rate(half_rate), .sense_col(sense_col),
    .drive_row(drive_row), .rd_strobe(rd_strobe), .code_out(code_out),
    .fifo_nempty(fifo_nempty), .fifo_ovf(fifo_ovf), .event_req(event_req),
    .idle(idle)
  );

  // Matrix model: a driven row also sees the fourth corner of a rectangle
  always_comb begin
    sense_col = '0;
    for (int r = 0; r < 8; r++) begin
      if (drive_row[r]) begin
        for (int c = 0; c < 12; c++) begin
          logic hit;
          hit = keys[r][c];
          for (int c2 = 0; c2 < 12; c2++)
            for (int r2 = 0; r2 < 8; r2++)
              if (keys[r][c2] && keys[r2][c2] && keys[r2][c]) hit = 1'b1;
          if (hit) sense_col[c] = 1'b1;
        end
      end
    end
  end

  function automatic logic [7:0] exp_code(int r, int c, bit rel);
    return (rel ? 8'h80 : 8'h00) | 8'((r << 4) + c + 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic read_expect(logic [7:0] exp, string req);
    @(negedge clk);
    if (!fifo_nempty) chk(0, req, 'hEE, exp);
    else begin
      chk(code_out == exp, req, code_out, exp);
      rd_strobe = 1;
      @(negedge clk);
      rd_strobe = 0;
    end
  endtask

  task automatic sync_row(int r);
    @(negedge clk);
    while (drive_row[r]) @(negedge clk);
    while (!drive_row[r]) @(negedge clk);
  endtask

  task automatic expect_empty(string req);
    @(negedge clk);
    chk(!fifo_nempty && !event_req, req, fifo_nempty, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!fifo_nempty && !fifo_ovf && idle, "R1 flags", {fifo_nempty, fifo_ovf, idle}, 3'b001);
    chk(drive_row == 8'h01, "R1 drive", drive_row, 1);
    rst_n = 1;

    // R2 R3 table of single keys
    for (int i = 0; i < 6; i++) begin
      int r, c;
      r = int'(VEC[i][15:12]);
      c = int'(VEC[i][11:8]);
      chk(exp_code(r, c, 0) == VEC[i][7:0], "R2 table", exp_code(r, c, 0), VEC[i][7:0]);
      keys[r][c] = 1;
      settle();
      chk(!idle, "R11 idle held", idle, 0);
      read_expect(VEC[i][7:0], "R2 make");
      expect_empty("R3 single byte");
      keys[r][c] = 0;
      settle();
      read_expect(VEC[i][7:0] | 8'h80, "R2 break");
      expect_empty("R3 no repeat");
      chk(idle, "R11 idle free", idle, 1);
    end

    // R4 one-scan glitch on row 2
    sync_row(2);
    keys[2][3] = 1;
    while (drive_row[2]) @(negedge clk);
    keys[2][3] = 0;
    settle();
    expect_empty("R4 glitch dropped");

    // R6 ordering within one scan, R7 several held keys
    sync_row(0);
    keys[3][5] = 1; keys[1][2] = 1; keys[1][9] = 1;
    settle();
    read_expect(8'h13, "R6 first");
    read_expect(8'h1A, "R6 second");
    read_expect(8'h36, "R6 third");
    sync_row(0);
    keys = '0;
    settle();
    read_expect(8'h93, "R7 break a");
    read_expect(8'h9A, "R7 break b");
    read_expect(8'hB6, "R7 break c");

    // R5 three corners of a rectangle
    sync_row(0);
    keys[0][0] = 1; keys[0][1] = 1; keys[1][0] = 1;
    settle();
    expect_empty("R5 ghost silent");
    keys[0][1] = 0;
    settle();
    read_expect(8'h01, "R5 after ghost a");
    read_expect(8'h11, "R5 after ghost b");
    sync_row(0);
    keys = '0;
    settle();
    read_expect(8'h81, "R5 release a");
    read_expect(8'h91, "R5 release b");

    // R8 disabled column and row
    col_en[11] = 0;
    keys[2][11] = 1;
    settle();
    expect_empty("R8 column off");
    keys[2][11] = 0;
    settle();
    col_en[11] = 1;
    row_en[7] = 0;
    keys[7][0] = 1;
    begin
      bit seen;
      seen = 0;
      repeat (SETTLE) begin
        @(negedge clk);
        if (drive_row[7]) seen = 1;
      end
      chk(!seen, "R8 row never driven", seen, 0);
    end
    expect_empty("R8 row off");
    keys[7][0] = 0;
    settle();
    row_en[7] = 1;

    // R9 R10 ten keys on one row overflow an 8-entry queue
    chk(!fifo_ovf, "R10 ovf clear", fifo_ovf, 0);
    sync_row(0);
    for (int c = 0; c < 10; c++) keys[0][c] = 1;
    settle();
    chk(fifo_ovf, "R10 ovf set", fifo_ovf, 1);
    for (int c = 0; c < 8; c++) read_expect(exp_code(0, c, 0), "R9 oldest first");
    expect_empty("R9 depth 8");
    chk(!idle, "R11 idle keys down", idle, 0);
    sync_row(0);
    keys = '0;
    settle();
    for (int c = 0; c < 8; c++) read_expect(exp_code(0, c, 1), "R7 all tracked");
    expect_empty("R10 extra dropped");
    chk(fifo_ovf && idle, "R10 sticky", {fifo_ovf, idle}, 2'b11);

    // R12 row dwell
    begin
      int cnt;
      scan_rate = 7'd3;
      settle();
      sync_row(0);
      cnt = 0;
      while (drive_row[0]) begin @(negedge clk); cnt++; end
      chk(cnt == 4, "R12 rate", cnt, 4);
      half_rate = 1;
      settle();
      sync_row(0);
      cnt = 0;
      while (drive_row[0]) begin @(negedge clk); cnt++; end
      chk(cnt == 8, "R12 halved", cnt, 8);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule